// File: doc/BRIEF.md
# Forty-Bit SIMD Multiply-Accumulator

This block holds one 40-bit signed accumulator and updates it from two 32-bit register operands, `src_a` (the multiplier) and `src_b` (the multiplicand). An operation code, presented with a one-cycle `start` pulse, selects the operation. Three of them multiply and accumulate: a 16x16 form that uses one chosen half of each operand, a dual packed form that adds two half-word products at once, and a full 32x32 form. Two more operations move the accumulator to or from a pair of 32-bit register values.

Every multiply is signed. Each product is sign-extended to 40 bits and then added, and the sum wraps modulo 2^40. Most operations finish in one cycle. A 32x32 operation finishes in one cycle when the multiplier fits in 16 signed bits. Otherwise it spends a second cycle on the upper half of the multiplier, and `busy` is high during that cycle. Completion is signalled by a one-cycle `done` pulse. The surrounding pipeline issues the next operation when it sees `done`, and reads move-out results at that point.

Top module: `mac40_unit`

## Requirements
- R1: A synchronous reset sets the accumulator to zero and drives `done` and `busy` low.
- R2: With op=0, the 16-bit halves selected by `a_hi_sel` and `b_hi_sel` (1 picks bits [31:16], 0 picks bits [15:0]) are multiplied as signed values. The 32-bit product, sign-extended to 40 bits, is added to the accumulator. All four half combinations are supported.
- R3: With op=1, the accumulator gains the signed product of the two upper halves plus the signed product of the two lower halves. Both products are sign-extended to 40 bits, and the half selects are ignored.
- R4: With op=2, the full 64-bit signed product of `src_a` and `src_b` is formed, and its low 40 bits are added to the accumulator.
- R5: An accepted op=2 raises `done` one cycle after `start` when `src_a[31:16]` are all copies of `src_a[15]`. Otherwise `done` rises two cycles after `start`, and `busy` is high in the cycle between.
- R6: With op=3, `out_lo` becomes accumulator bits [31:0] and `out_hi` becomes accumulator bits [39:32] sign-extended to 32 bits. The accumulator is left unchanged.
- R7: With op=4, the accumulator is loaded with `src_a` as bits [31:0] and `src_b[7:0]` as bits [39:32]. `src_b[31:8]` has no effect.
- R8: Accumulation wraps modulo 2^40 and never saturates.
- R9: A `start` that arrives while `busy` is high is ignored.
- R10: Op codes 5 to 7 produce a `done` pulse one cycle after `start` and leave the accumulator and the move-out registers unchanged.
- R11: Every accepted operation except a long op=2 produces `done` exactly one cycle after `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue pulse for one operation |
| op | input | 3 | Operation code (0 half MAC, 1 dual MAC, 2 full MAC, 3 move out, 4 move in) |
| a_hi_sel | input | 1 | Half select of `src_a` for op=0 |
| b_hi_sel | input | 1 | Half select of `src_b` for op=0 |
| src_a | input | 32 | Multiplier, or accumulator low word for op=4 |
| src_b | input | 32 | Multiplicand, or accumulator top byte for op=4 |
| busy | output | 1 | Second cycle of a long 32x32 operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| acc | output | 40 | Current accumulator value |
| out_lo | output | 32 | Move-out low word |
| out_hi | output | 32 | Move-out sign-extended top byte |

## Verification
The directed cases use negative operands in every half combination. A design that zero-extends a product or picks the wrong half would therefore land on a different sum. Full multiplies are tried with a multiplier that only just fits in 16 signed bits and with one that does not, checking both the result and the latency. An early-exit test that looks at the wrong bits would show up as a one-cycle error or as a wrong product. The accumulator is preloaded at all ones and at sign boundaries to catch saturation or a dropped carry. The move-out high word is checked with both a positive and a negative top byte. A start issued during the busy cycle must leave no trace, and that catches a controller that accepts it.

// File: rtl/mac40_pkg.sv
package mac40_pkg;

    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;
    localparam int ACC_W  = 40;
    localparam int PROD_W = 2 * DATA_W;
    localparam int TOP_W  = ACC_W - DATA_W;

    typedef enum logic [2:0] {
        OPC_MAC16  = 3'd0,
        OPC_DUAL   = 3'd1,
        OPC_MAC32  = 3'd2,
        OPC_MOVOUT = 3'd3,
        OPC_MOVIN  = 3'd4
    } opc_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_TAIL = 1'b1
    } phase_e;

    typedef struct packed {
        logic [PROD_W-1:0] part;
        logic [HALF_W-1:0] mhi;
        logic [DATA_W-1:0] mcand;
    } tail_t;

    function automatic logic [ACC_W-1:0] sext_half_prod(input logic [DATA_W-1:0] p);
        return {{(ACC_W - DATA_W){p[DATA_W-1]}}, p};
    endfunction

    function automatic logic [HALF_W-1:0] pick_half(input logic [DATA_W-1:0] v,
                                                    input logic hi);
        return hi ? v[DATA_W-1:HALF_W] : v[HALF_W-1:0];
    endfunction

endpackage

// File: rtl/mac40_halfmul.sv
module mac40_halfmul #(
    parameter int HW = 16
) (
    input  logic [HW-1:0]   x,
    input  logic [HW-1:0]   y,
    output logic [2*HW-1:0] p
);
    logic signed [HW-1:0]   xs;
    logic signed [HW-1:0]   ys;
    logic signed [2*HW-1:0] ps;

    assign xs = x;
    assign ys = y;
    assign ps = xs * ys;
    assign p  = ps;
endmodule

// File: rtl/mac40_lanes.sv
module mac40_lanes
    import mac40_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              a_hi,
    input  logic              b_hi,
    input  logic              dual,
    output logic [ACC_W-1:0]  sum
);
    localparam int LANES = 2;

    logic [ACC_W-1:0] lane_ext [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [HALF_W-1:0] xa;
        logic [HALF_W-1:0] yb;
        logic [DATA_W-1:0] pr;

        if (g == 0) begin : g_sel
            assign xa = pick_half(a, a_hi & ~dual);
            assign yb = pick_half(b, b_hi & ~dual);
        end else begin : g_fix
            assign xa = a[DATA_W-1:HALF_W];
            assign yb = b[DATA_W-1:HALF_W];
        end

        mac40_halfmul #(.HW(HALF_W)) u_mul (
            .x(xa),
            .y(yb),
            .p(pr)
        );

        if (g == 0) begin : g_ext0
            assign lane_ext[g] = sext_half_prod(pr);
        end else begin : g_ext1
            assign lane_ext[g] = dual ? sext_half_prod(pr) : '0;
        end
    end

    assign sum = lane_ext[0] + lane_ext[1];
endmodule

// File: rtl/mac40_wide.sv
module mac40_wide
    import mac40_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  tail_t             held,
    output logic              early,
    output logic [PROD_W-1:0] short_prod,
    output logic [PROD_W-1:0] low_part,
    output logic [PROD_W-1:0] tail_prod
);
    localparam int LO_W = DATA_W + HALF_W + 1;
    localparam int SH_W = DATA_W + HALF_W;

    logic signed [HALF_W:0]   a_lo_u;
    logic signed [DATA_W-1:0] b_s;
    logic signed [HALF_W-1:0] a_lo_s;
    logic signed [LO_W-1:0]   lo_full;
    logic signed [SH_W-1:0]   sh_full;
    logic signed [HALF_W-1:0] mhi_s;
    logic signed [DATA_W-1:0] mc_s;
    logic signed [SH_W-1:0]   hi_full;
    logic [PROD_W-1:0]        hi_shift;

    assign early = (a[DATA_W-1:HALF_W] == {HALF_W{a[HALF_W-1]}});

    assign b_s     = b;
    assign a_lo_s  = a[HALF_W-1:0];
    assign a_lo_u  = {1'b0, a[HALF_W-1:0]};
    assign lo_full = a_lo_u * b_s;
    assign sh_full = a_lo_s * b_s;

    assign low_part   = {{(PROD_W - LO_W){lo_full[LO_W-1]}}, lo_full};
    assign short_prod = {{(PROD_W - SH_W){sh_full[SH_W-1]}}, sh_full};

    assign mhi_s    = held.mhi;
    assign mc_s     = held.mcand;
    assign hi_full  = mhi_s * mc_s;
    assign hi_shift = {{(PROD_W - SH_W){hi_full[SH_W-1]}}, hi_full} << HALF_W;
    assign tail_prod = held.part + hi_shift;
endmodule

// File: rtl/mac40_unit.sv
module mac40_unit
    import mac40_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic              a_hi_sel,
    input  logic              b_hi_sel,
    input  logic [31:0]       src_a,
    input  logic [31:0]       src_b,
    output logic              busy,
    output logic              done,
    output logic [39:0]       acc,
    output logic [31:0]       out_lo,
    output logic [31:0]       out_hi
);
    phase_e            phase_q;
    logic [ACC_W-1:0]  acc_q;
    logic              done_q;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] hi_q;
    tail_t             tail_q;

    logic [ACC_W-1:0]  lane_sum;
    logic              early;
    logic [PROD_W-1:0] short_prod;
    logic [PROD_W-1:0] low_part;
    logic [PROD_W-1:0] tail_prod;
    logic              accept;

    assign accept = start && (phase_q == PH_IDLE);

    mac40_lanes u_lanes (
        .a    (src_a),
        .b    (src_b),
        .a_hi (a_hi_sel),
        .b_hi (b_hi_sel),
        .dual (op == OPC_DUAL),
        .sum  (lane_sum)
    );

    mac40_wide u_wide (
        .a          (src_a),
        .b          (src_b),
        .held       (tail_q),
        .early      (early),
        .short_prod (short_prod),
        .low_part   (low_part),
        .tail_prod  (tail_prod)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            acc_q   <= '0;
            done_q  <= 1'b0;
            lo_q    <= '0;
            hi_q    <= '0;
            tail_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (phase_q == PH_TAIL) begin
                acc_q   <= acc_q + tail_prod[ACC_W-1:0];
                done_q  <= 1'b1;
                phase_q <= PH_IDLE;
            end else if (accept) begin
                case (op)
                    OPC_MAC16, OPC_DUAL: begin
                        acc_q  <= acc_q + lane_sum;
                        done_q <= 1'b1;
                    end
                    OPC_MAC32: begin
                        if (early) begin
                            acc_q  <= acc_q + short_prod[ACC_W-1:0];
                            done_q <= 1'b1;
                        end else begin
                            tail_q.part  <= low_part;
                            tail_q.mhi   <= src_a[DATA_W-1:HALF_W];
                            tail_q.mcand <= src_b;
                            phase_q      <= PH_TAIL;
                        end
                    end
                    OPC_MOVOUT: begin
                        lo_q   <= acc_q[DATA_W-1:0];
                        hi_q   <= {{(DATA_W - TOP_W){acc_q[ACC_W-1]}}, acc_q[ACC_W-1:DATA_W]};
                        done_q <= 1'b1;
                    end
                    OPC_MOVIN: begin
                        acc_q  <= {src_b[TOP_W-1:0], src_a};
                        done_q <= 1'b1;
                    end
                    default: begin
                        done_q <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign busy   = (phase_q == PH_TAIL);
    assign done   = done_q;
    assign acc    = acc_q;
    assign out_lo = lo_q;
    assign out_hi = hi_q;

    // R1: the first cycle after reset shows a cleared accumulator
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (acc == '0 && !done && !busy));

    // R5: the busy cycle lasts exactly one cycle and ends in done
    assert_tail_single_R5: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy && done));

    // R11: operations other than a full multiply finish in one cycle
    assert_short_done_R11: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op != OPC_MAC32) |=> (done && !busy));

    // R6: a move-out leaves the accumulator where it was
    assert_movout_keep_R6: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op == OPC_MOVOUT) |=> $stable(acc));

    // R6: the move-out low word mirrors the accumulator low word
    assert_movout_word_R6: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op == OPC_MOVOUT) |=> (out_lo == $past(acc[31:0])));

    // R9: a start during the busy cycle does not open a new operation
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> !busy);
endmodule

// File: tb/mac40_unit_test.sv
module mac40_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic        a_hi_sel = 1'b0;
    logic        b_hi_sel = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        busy;
    logic        done;
    logic [39:0] acc;
    logic [31:0] out_lo;
    logic [31:0] out_hi;

    int          n_checks = 0;
    int          n_errors = 0;
    logic [39:0] exp_acc = '0;

    always #2.5 clk = ~clk;

    mac40_unit uut (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .a_hi_sel(a_hi_sel), .b_hi_sel(b_hi_sel),
        .src_a(src_a), .src_b(src_b),
        .busy(busy), .done(done), .acc(acc),
        .out_lo(out_lo), .out_hi(out_hi)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic issue(input logic [2:0] o, input logic ah, input logic bh,
                         input logic [31:0] a, input logic [31:0] b,
                         output int lat, output logic saw_busy);
        @(negedge clk);
        start = 1'b1; op = o; a_hi_sel = ah; b_hi_sel = bh; src_a = a; src_b = b;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        saw_busy = busy;
        while (!done && lat < 8) begin
            @(negedge clk);
            lat++;
        end
    endtask

    function automatic logic [39:0] prod16(input logic [15:0] x, input logic [15:0] y);
        longint p;
        p = longint'($signed(x)) * longint'($signed(y));
        return p[39:0];
    endfunction

    task automatic load_acc(input logic [39:0] v);
        int l; logic bz;
        issue(3'd4, 1'b0, 1'b0, v[31:0], {24'hABCDEF, v[39:32]}, l, bz);
        exp_acc = v;
    endtask

    task automatic t_reset;
        check("R1 acc", {24'h0, acc}, 64'h0);
        check("R1 done", {63'h0, done}, 64'h0);
        check("R1 busy", {63'h0, busy}, 64'h0);
    endtask

    task automatic t_moves;
        int l; logic bz;
        issue(3'd4, 1'b0, 1'b0, 32'h89AB_CDEF, 32'hFFFF_FF5A, l, bz);
        check("R7 movin", {24'h0, acc}, 64'h5A_89AB_CDEF);
        issue(3'd3, 1'b0, 1'b0, 32'h0, 32'h0, l, bz);
        check("R6 out_lo", {32'h0, out_lo}, 64'h89AB_CDEF);
        check("R6 out_hi pos", {32'h0, out_hi}, 64'h0000_005A);
        check("R6 acc kept", {24'h0, acc}, 64'h5A_89AB_CDEF);
        check("R11 movout latency", l, 1);
        issue(3'd4, 1'b0, 1'b0, 32'h0000_0001, 32'h1234_5680, l, bz);
        issue(3'd3, 1'b0, 1'b0, 32'h0, 32'h0, l, bz);
        check("R6 out_hi neg", {32'h0, out_hi}, 64'hFFFF_FF80);
        check("R7 upper bits ignored", {24'h0, acc}, 64'h80_0000_0001);
    endtask

    task automatic t_mac16;
        int l; logic bz;
        logic [31:0] a = 32'h8001_FFFD;
        logic [31:0] b = 32'h0007_FFF0;
        load_acc(40'h00_0000_0100);
        for (int k = 0; k < 4; k++) begin
            logic ah = k[1];
            logic bh = k[0];
            issue(3'd0, ah, bh, a, b, l, bz);
            exp_acc = exp_acc + prod16(ah ? a[31:16] : a[15:0], bh ? b[31:16] : b[15:0]);
            check($sformatf("R2 half combo %0d", k), {24'h0, acc}, {24'h0, exp_acc});
            check("R11 mac16 latency", l, 1);
        end
    endtask

    task automatic t_dual;
        int l; logic bz;
        logic [31:0] a = 32'hFF00_7FFF;
        logic [31:0] b = 32'h0100_8000;
        load_acc(40'h00_0000_0000);
        issue(3'd1, 1'b1, 1'b0, a, b, l, bz);
        exp_acc = prod16(a[31:16], b[31:16]) + prod16(a[15:0], b[15:0]);
        check("R3 dual sum", {24'h0, acc}, {24'h0, exp_acc});
        check("R11 dual latency", l, 1);
    endtask

    task automatic t_mac32(input logic [31:0] a, input logic [31:0] b, input int exp_lat);
        int l; logic bz;
        longint p;
        issue(3'd2, 1'b0, 1'b0, a, b, l, bz);
        p = longint'($signed(a)) * longint'($signed(b));
        exp_acc = exp_acc + p[39:0];
        check("R4 mac32 value", {24'h0, acc}, {24'h0, exp_acc});
        check("R5 mac32 latency", l, exp_lat);
        check("R5 busy seen", {63'h0, bz}, {63'h0, exp_lat == 2});
    endtask

    task automatic t_wrap;
        int l; logic bz;
        load_acc(40'hFF_FFFF_FFFF);
        issue(3'd0, 1'b0, 1'b0, 32'h1, 32'h1, l, bz);
        check("R8 wrap up", {24'h0, acc}, 64'h0);
        load_acc(40'h7F_FFFF_FFFF);
        issue(3'd0, 1'b0, 1'b0, 32'h1, 32'h1, l, bz);
        check("R8 no saturation", {24'h0, acc}, 64'h80_0000_0000);
        exp_acc = 40'h80_0000_0000;
    endtask

    task automatic t_busy_ignore;
        longint p;
        logic [31:0] a = 32'h7654_3210;
        logic [31:0] b = 32'hF000_0003;
        load_acc(40'h00_0000_1000);
        @(negedge clk);
        start = 1'b1; op = 3'd2; src_a = a; src_b = b;
        @(negedge clk);
        check("R9 busy high", {63'h0, busy}, 64'h1);
        op = 3'd4; src_a = 32'h0; src_b = 32'h0;
        @(negedge clk);
        start = 1'b0;
        p = longint'($signed(a)) * longint'($signed(b));
        exp_acc = exp_acc + p[39:0];
        check("R9 done after tail", {63'h0, done}, 64'h1);
        @(negedge clk);
        check("R9 start ignored", {24'h0, acc}, {24'h0, exp_acc});
        check("R9 no extra done", {63'h0, done}, 64'h0);
    endtask

    task automatic t_invalid;
        int l; logic bz;
        logic [31:0] lo0;
        logic [31:0] hi0;
        lo0 = out_lo; hi0 = out_hi;
        for (int c = 5; c < 8; c++) begin
            issue(3'(c), 1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, l, bz);
            check("R10 latency", l, 1);
            check("R10 acc kept", {24'h0, acc}, {24'h0, exp_acc});
            check("R10 out kept", {out_hi, out_lo}, {hi0, lo0});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_moves();
        t_mac16();
        t_dual();
        load_acc(40'h00_0000_0000);
        t_mac32(32'hFFFF_8001, 32'h8000_0000, 1);
        t_mac32(32'h0000_7FFF, 32'h7FFF_FFFF, 1);
        t_mac32(32'h0000_8000, 32'h7FFF_FFFF, 2);
        t_mac32(32'h8000_0000, 32'h8000_0000, 2);
        t_mac32(32'h1234_5678, 32'hDEAD_BEEF, 2);
        t_wrap();
        t_busy_ignore();
        t_invalid();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule